// File: doc/BRIEF.md
# Interleaved Digitizer Sequencer and Framer

This block is the control logic of a 32-channel time-multiplexed digitizer clocked at 40 MHz. The channels form two 16-channel halves, and the two halves are scanned in lockstep, so channel n is always read together with channel n+16. Each half has two 8-channel blocks: one carries the even channels and the other carries the odd channels. Each 8-channel block has two 4-input analog multiplexers with outputs tied together, and these feed one 20 MHz ADC. The block drives the multiplexer enables and addresses. It toggles a 2:1 digital selector between the even ADC and the odd ADC on every clock. It packs the two selected samples into a 21-bit link word, one word per clock.

A frame is 16 words, with n running from 0 to 15. The ADCs are modelled as sample inputs that arrive a fixed number of ADC conversions after the analog select that produced them. For this reason the block issues each select `2*ADC_LAT` clocks ahead of the word that consumes it. Words that are framed before this lead is covered are marked invalid.

A board hold input holds the whole block in reset and stops the scan. An acquisition-active output shows when the scan is running.

Top module: `ilvd_seq_framer`

## Requirements
- R1: While `hold` is high, after the next clock edge `link_valid`, `acq_active` and `link_word` are all zero. Every analog multiplexer enable is also low during hold.
- R2: `acq_active` goes high on the first clock edge after `hold` falls. It stays high for as long as `hold` stays low.
- R3: The k-th word after release (k = 0, 1, ...) carries n = k mod 16. Bits 19..10 hold the sample of channel n and bits 9..0 hold the sample of channel n+16.
- R4: Bit 20 (SYNC) is 1 only on words with n = 15 and is 0 on all other words.
- R5: `dsel_odd` is 1 while the current word index n is odd and 0 while it is even. Each word's samples come from the ADCs of the matching parity. ADC index b = 2*half + parity, its sample is `adc_in[10*b +: 10]`, and parity 1 means odd.
- R6: Each 8-channel block b has two enables, `amux_en[2b+1:2b]`, and a 2-bit address, `amux_addr[2b+1:2b]`. While running, exactly one of the two enables is high. The block-local index is k = 4*(upper enable) + address, and it selects channel 16*half + 2k + parity. Each block steps k upward once per two clocks, and all blocks of the same parity carry the same k.
- R7: The select is issued `2*ADC_LAT` clocks ahead of use. The sample present on `adc_in` at the edge that frames word n is therefore the sample of the channel that word n needs.
- R8: `link_valid` is low for the first `2*ADC_LAT` words after release. It is high for every word after that, until hold.
- R9: If hold is asserted in the middle of a frame and then released, the scan restarts at n = 0 with SYNC low and `link_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz link clock |
| hold | input | 1 | Board hold; high holds the block in reset |
| adc_in | input | 40 | Four ADC samples, ADC b in bits 10b+9..10b |
| amux_en | output | 8 | Analog multiplexer enables, two per block |
| amux_addr | output | 8 | 2-bit analog multiplexer address per block |
| dsel_odd | output | 1 | Digital selector: 1 = odd-channel ADC (input A) |
| link_word | output | 21 | SYNC, channel n sample, channel n+16 sample |
| link_valid | output | 1 | Word carries pipeline-filled data |
| acq_active | output | 1 | Acquisition running |

## Verification
The bench models the ADCs as a delay line that turns the select outputs into channel-tagged sample values. It therefore exposes three kinds of error: a wrong multiplexer decode, a wrong lead, and a swapped parity. Any of these puts another channel's tag into a word field. An alternating all-ones/all-zeros pattern exposes a field swap or a misplaced bit. The bench checks the boundary between invalid and valid words at word `2*ADC_LAT`, so a design with an off-by-one fill count shows a data mismatch or a missing valid. A mid-frame hold followed by release catches a word counter that resumes instead of restarting, and catches a SYNC bit that appears outside n = 15.

// File: rtl/ilvd_pkg.sv
package ilvd_pkg;
    localparam int N_HALF      = 2;
    localparam int N_PAR       = 2;
    localparam int N_ADC       = N_HALF * N_PAR;
    localparam int MUX_PER_ADC = 2;
    localparam int ADDR_W      = 2;
    localparam int WORDS       = 16;
    localparam int WIDX_W      = $clog2(WORDS);
    localparam int LOC_W       = $clog2(MUX_PER_ADC) + ADDR_W;

    typedef logic [WIDX_W-1:0] widx_t;
endpackage

// File: rtl/ilvd_seq_ctrl.sv
module ilvd_seq_ctrl
    import ilvd_pkg::*;
#(
    parameter int LEAD = 6
) (
    input  logic  clk,
    input  logic  hold,
    output widx_t word_idx,
    output widx_t lead_idx,
    output logic  fill_done,
    output logic  running
);
    localparam int FILL_W = $clog2(LEAD + 1);

    typedef struct packed {
        widx_t             word;
        logic [FILL_W-1:0] fill;
        logic              run;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hold) begin
            s_d.word = '0;
            s_d.fill = '0;
            s_d.run  = 1'b0;
        end else begin
            s_d.word = s_q.word + 1'b1;
            s_d.run  = 1'b1;
            if (s_q.fill != FILL_W'(LEAD))
                s_d.fill = s_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign word_idx  = s_q.word;
    assign lead_idx  = s_q.word + WIDX_W'(LEAD);
    assign fill_done = (s_q.fill == FILL_W'(LEAD));
    assign running   = s_q.run;

    // R3: the word index advances by one, modulo the frame length, on every running clock
    a_r3_word_step: assert property (@(posedge clk) disable iff (hold)
        s_q.run |=> s_q.word == WIDX_W'($past(s_q.word) + 1'b1));

    // R9: hold restarts the frame at word 0
    a_r9_hold_restart: assert property (@(posedge clk)
        hold |=> (s_q.word == '0 && !s_q.run));

    // R8: the fill count never passes the lead
    a_r8_fill_cap: assert property (@(posedge clk) disable iff (hold)
        s_q.run |-> s_q.fill <= FILL_W'(LEAD));
endmodule

// File: rtl/ilvd_amux_drv.sv
module ilvd_amux_drv
    import ilvd_pkg::*;
#(
    parameter int PARITY = 0
) (
    input  logic                   clk,
    input  logic                   hold,
    input  widx_t                  lead_idx,
    output logic [MUX_PER_ADC-1:0] mux_en,
    output logic [ADDR_W-1:0]      addr
);
    logic [LOC_W-1:0] loc;
    widx_t            adj;

    always_comb begin
        // Target the next word of this block's parity at or after the lead point.
        adj    = widx_t'(lead_idx[0] != 1'(PARITY));
        loc    = LOC_W'((lead_idx + adj) >> 1);
        mux_en = '0;
        if (!hold)
            mux_en[loc[LOC_W-1:ADDR_W]] = 1'b1;
        addr   = loc[ADDR_W-1:0];
    end

    // R6: the tied multiplexer outputs never see two drivers, and never none while running
    a_r6_one_mux: assert property (@(posedge clk) disable iff (hold)
        $countones(mux_en) == 1);

    // R6: the select holds for a full conversion (two clocks)
    a_r6_sel_hold2: assert property (@(posedge clk) disable iff (hold)
        ($past(!hold) && lead_idx[0] == 1'(PARITY)) |-> $stable({mux_en, addr}));
endmodule

// File: rtl/ilvd_framer.sv
module ilvd_framer
    import ilvd_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic                      clk,
    input  logic                      hold,
    input  widx_t                     word_idx,
    input  logic                      fill_done,
    input  logic [N_ADC*SAMPLE_W-1:0] adc_in,
    output logic [2*SAMPLE_W:0]       word,
    output logic                      valid,
    output logic                      dsel_odd
);
    localparam int WORD_W = 2 * SAMPLE_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
    } frm_t;

    frm_t f_d, f_q;
    logic              par;
    logic [SAMPLE_W-1:0] s_lo_half, s_hi_half;

    always_comb begin
        par       = word_idx[0];
        s_lo_half = adc_in[(0 * N_PAR + int'(par)) * SAMPLE_W +: SAMPLE_W];
        s_hi_half = adc_in[(1 * N_PAR + int'(par)) * SAMPLE_W +: SAMPLE_W];
        f_d = f_q;
        if (hold) begin
            f_d.word  = '0;
            f_d.valid = 1'b0;
        end else begin
            f_d.word  = {word_idx == widx_t'(WORDS - 1), s_lo_half, s_hi_half};
            f_d.valid = fill_done;
        end
    end

    always_ff @(posedge clk) begin
        f_q <= f_d;
    end

    assign word     = f_q.word;
    assign valid    = f_q.valid;
    assign dsel_odd = par;

    // R4: SYNC only on the last pair of the frame
    a_r4_sync_last: assert property (@(posedge clk) disable iff (hold)
        f_q.word[WORD_W-1] |-> $past(word_idx) == widx_t'(WORDS - 1));

    // R1: hold clears the output word and its strobe
    a_r1_hold_quiet: assert property (@(posedge clk)
        hold |=> (f_q.word == '0 && !f_q.valid));

    // R8: once valid, words stay valid until the next hold
    a_r8_valid_sticky: assert property (@(posedge clk) disable iff (hold)
        f_q.valid |=> f_q.valid);
endmodule

// File: rtl/ilvd_seq_framer.sv
module ilvd_seq_framer
    import ilvd_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int ADC_LAT  = 3
) (
    input  logic                          clk,
    input  logic                          hold,
    input  logic [N_ADC*SAMPLE_W-1:0]     adc_in,
    output logic [N_ADC*MUX_PER_ADC-1:0]  amux_en,
    output logic [N_ADC*ADDR_W-1:0]       amux_addr,
    output logic                          dsel_odd,
    output logic [2*SAMPLE_W:0]           link_word,
    output logic                          link_valid,
    output logic                          acq_active
);
    localparam int LEAD = 2 * ADC_LAT;

    widx_t word_idx, lead_idx;
    logic  fill_done;

    ilvd_seq_ctrl #(.LEAD(LEAD)) u_seq (
        .clk       (clk),
        .hold      (hold),
        .word_idx  (word_idx),
        .lead_idx  (lead_idx),
        .fill_done (fill_done),
        .running   (acq_active)
    );

    for (genvar b = 0; b < N_ADC; b++) begin : g_blk
        ilvd_amux_drv #(.PARITY(b % N_PAR)) u_drv (
            .clk      (clk),
            .hold     (hold),
            .lead_idx (lead_idx),
            .mux_en   (amux_en[b*MUX_PER_ADC +: MUX_PER_ADC]),
            .addr     (amux_addr[b*ADDR_W +: ADDR_W])
        );
    end

    ilvd_framer #(.SAMPLE_W(SAMPLE_W)) u_frm (
        .clk       (clk),
        .hold      (hold),
        .word_idx  (word_idx),
        .fill_done (fill_done),
        .adc_in    (adc_in),
        .word      (link_word),
        .valid     (link_valid),
        .dsel_odd  (dsel_odd)
    );

    // R2: acquisition indicator follows release of hold
    a_r2_active_on_release: assert property (@(posedge clk)
        !hold |=> acq_active);
endmodule

// File: tb/ilvd_seq_framer_test.sv
module ilvd_seq_framer_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SW   = 10;
    localparam int LAT  = 3;
    localparam int LEAD = 2 * LAT;

    logic          clk = 1'b0;
    logic          hold = 1'b1;
    logic [4*SW-1:0] adc_in;
    logic [7:0]    amux_en;
    logic [7:0]    amux_addr;
    logic          dsel_odd;
    logic [2*SW:0] link_word;
    logic          link_valid;
    logic          acq_active;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int pat   = 0;
    int seed  = 1;

    logic [SW-1:0] line [LEAD][4];

    ilvd_seq_framer #(.SAMPLE_W(SW), .ADC_LAT(LAT)) uut (
        .clk(clk), .hold(hold), .adc_in(adc_in), .amux_en(amux_en),
        .amux_addr(amux_addr), .dsel_odd(dsel_odd), .link_word(link_word),
        .link_valid(link_valid), .acq_active(acq_active)
    );

    always #2.5 clk = ~clk;

    function automatic logic [SW-1:0] chan_val(int ch);
        if (pat == 1) return (ch % 2 == 1) ? 10'h3FF : 10'h000;
        return 10'((ch * 29 + seed * 7 + 3) & 1023);
    endfunction

    // ADC model: sample whichever channel the select points to, deliver LEAD clocks later
    function automatic logic [SW-1:0] adc_sample(int b);
        logic [1:0] en;
        int k;
        en = amux_en[b*2 +: 2];
        if (en == 2'b01)      k = int'(amux_addr[b*2 +: 2]);
        else if (en == 2'b10) k = 4 + int'(amux_addr[b*2 +: 2]);
        else return 10'h2AA;
        return chan_val(16 * (b / 2) + 2 * k + (b % 2));
    endfunction

    always @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            line[0][b] <= adc_sample(b);
            for (int i = 1; i < LEAD; i++) line[i][b] <= line[i-1][b];
        end
    end

    always_comb begin
        for (int b = 0; b < 4; b++) adc_in[b*SW +: SW] = line[LEAD-1][b];
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual=%0d cycles expected<=20000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check_held(string tag);
        chk({tag, " R1 valid"}, 32'(link_valid), 0);
        chk({tag, " R1 active"}, 32'(acq_active), 0);
        chk({tag, " R1 enables"}, 32'(amux_en), 0);
        chk({tag, " R1 word"}, 32'(link_word), 0);
    endtask

    // Release hold and check ncyc words of the stream
    task automatic run_stream(string tag, int ncyc);
        @(negedge clk);
        hold = 1'b0;
        for (int c = 1; c <= ncyc; c++) begin
            int k, n, ld, idx;
            @(posedge clk);
            @(negedge clk);
            k = c - 1;
            n = k % 16;
            chk({tag, " R2 active"}, 32'(acq_active), 1);
            chk({tag, " R8 valid"}, 32'(link_valid), 32'(k >= LEAD));
            chk({tag, " R4 sync"}, 32'(link_word[20]), 32'(n == 15));
            if (c == 1) begin
                chk({tag, " R9 first sync"}, 32'(link_word[20]), 0);
                chk({tag, " R9 first valid"}, 32'(link_valid), 0);
            end
            if (k >= LEAD) begin
                chk({tag, " R3 R7 ch n"}, 32'(link_word[19:10]), 32'(chan_val(n)));
                chk({tag, " R3 R7 ch n+16"}, 32'(link_word[9:0]), 32'(chan_val(n + 16)));
            end
            chk({tag, " R5 dsel"}, 32'(dsel_odd), 32'(c % 2));
            ld = (c + LEAD) % 16;
            for (int b = 0; b < 4; b++) begin
                idx = (b % 2 == 1) ? (ld >> 1) : (((ld + 1) >> 1) & 7);
                chk({tag, " R6 en"}, 32'(amux_en[b*2 +: 2]), 32'(1 << (idx >> 2)));
                chk({tag, " R6 addr"}, 32'(amux_addr[b*2 +: 2]), 32'(idx & 3));
            end
        end
    endtask

    task automatic t_reset_state();
        hold = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_held("reset");
    endtask

    task automatic t_stream_counting();
        pat = 0; seed = 1;
        run_stream("count", 48);
    endtask

    task automatic t_stream_alternating();
        @(negedge clk);
        hold = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_held("alt-hold");
        pat = 1;
        repeat (2) @(posedge clk);
        run_stream("alt", 40);
    endtask

    task automatic t_restart_midframe();
        @(negedge clk);
        hold = 1'b1;
        pat = 0; seed = 5;
        @(posedge clk);
        @(negedge clk);
        check_held("midhold");
        run_stream("pre", 21);
        @(negedge clk);
        hold = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_held("restart-hold");
        seed = 9;
        run_stream("restart", 36);
    endtask

    initial begin
        t_reset_state();
        t_stream_counting();
        t_stream_alternating();
        t_restart_midframe();
        summary();
        $finish;
    end
endmodule